// File: doc/BRIEF.md
# DMA Byte-Lane Realigner and Packer

This block sits between the read side of a DMA engine and its staging buffer. Each accepted read beat carries one source transfer whose bytes sit in lanes set by the running source address. The block rotates those bytes into the lanes that the running destination address needs. The entries it produces can then be written to the destination unchanged. Only the destination address and the destination mode decide where a byte ends up.

In incrementing mode, consecutive transfers are packed into full-width entries. Bytes that run past the top lane are kept in a residue register and start the next entry. The last beat of a transfer forces out any partial entry. In fixed mode, every beat produces its own entry in the lanes at the fixed destination offset. Each entry carries a byte-strobe mask. Output uses a valid/ready handshake, and input is held off while an entry cannot leave.

Top module: `dma_lane_packer`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are both low. No beat is accepted until a configuration has been loaded with `cfg_start`.
- R2: A `cfg_start` pulse is acted on only when the block is idle, meaning no transfer is open and no residue entry is pending. A pulse seen during a transfer has no effect on any later output entry.
- R3: Byte k of a beat is taken from lane (S+k) mod NB, where S is the running source offset. It is placed in lane (D+k) mod NB of the output, where D is the running destination offset. NB is the number of byte lanes, which is 8 by default.
- R4: A size code c (0..3 by default) means each beat carries 2^c bytes. After every beat the source offset advances by 2^c, modulo NB.
- R5: In incrementing mode, bytes fill lanes in rising order from the destination start offset. An entry is emitted as soon as lane NB-1 has been filled. Its strobe bit i is 1 exactly when lane i holds a byte.
- R6: In incrementing mode, bytes of a beat that wrap past lane NB-1 are held back. They are placed from lane 0 upward in the next entry.
- R7: When the last beat is accepted, any partial entry is emitted. If that beat also wraps, two entries are emitted in order and `in_ready` stays low in between. After the last beat, `in_ready` stays low until a new configuration is loaded.
- R8: In fixed mode, each beat yields exactly one entry. Its strobe covers 2^c lanes starting at the destination offset (wrapping modulo NB), and the destination offset never moves.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_strb` hold their values and `in_ready` is low.
- R10: Every emitted entry has at least one strobe bit set. Lanes without a strobe read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Loads a new transfer configuration when idle |
| cfg_src_ofs | input | 3 | Source start offset within a bus word |
| cfg_dst_ofs | input | 3 | Destination start offset within a bus word |
| cfg_size | input | 2 | Transfer size code, 2^code bytes per beat |
| cfg_dst_fixed | input | 1 | 1 = fixed destination, 0 = incrementing |
| in_valid | input | 1 | Read beat valid |
| in_ready | output | 1 | Read beat accepted when high with in_valid |
| in_data | input | 64 | Read beat data, source lanes |
| in_last | input | 1 | Marks the final beat of the transfer |
| out_valid | output | 1 | Entry valid |
| out_ready | input | 1 | Downstream accepts the entry |
| out_data | output | 64 | Entry data, destination lanes |
| out_strb | output | 8 | Entry byte strobes |

## Verification
A wrong destination pointer or residue shows up at the very next emitted entry as a misplaced byte or a wrong strobe. Every later entry of the same transfer then stays shifted. A lost residue shows up at the end of the transfer: the final entry is missing, or bytes are missing from its low lanes. A stale pending flag shows up as `in_ready` stuck low, or as an extra entry before the next transfer. The bench compares each entry byte for byte against a model kept one byte at a time. It runs the cases with the output side stalling at random.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    DST_INCR  = 1'b0,
    DST_FIXED = 1'b1
  } dst_mode_e;
endpackage

// File: rtl/dlp_rst_sync.sv
module dlp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dlp_lane_rotator.sv
module dlp_lane_rotator #(
  parameter int NB = 8
) (
  input  logic [NB*8-1:0]         din,
  input  logic [$clog2(NB)-1:0]   amount,
  output logic [NB*8-1:0]         dout
);
  localparam int OFS_W = $clog2(NB);

  for (genvar j = 0; j < NB; j++) begin : g_lane
    logic [OFS_W-1:0] pick;
    assign pick = OFS_W'(j) - amount;
    assign dout[j*8 +: 8] = din[int'(pick)*8 +: 8];
  end
endmodule

// File: rtl/dlp_lane_window.sv
module dlp_lane_window #(
  parameter int NB = 8
) (
  input  logic [$clog2(NB)-1:0] base,
  input  logic [$clog2(NB):0]   count,
  output logic [NB-1:0]         low_lanes,
  output logic [NB-1:0]         wrap_lanes,
  output logic [$clog2(NB)-1:0] next_base,
  output logic                  crosses
);
  localparam int OFS_W = $clog2(NB);
  localparam int SUM_W = OFS_W + 2;

  logic [SUM_W-1:0] end_pos;

  assign end_pos   = {2'b00, base} + {1'b0, count};
  assign next_base = end_pos[OFS_W-1:0];
  assign crosses   = (end_pos >= SUM_W'(NB));

  for (genvar j = 0; j < NB; j++) begin : g_win
    assign low_lanes[j]  = (SUM_W'(j) >= {2'b00, base}) && (SUM_W'(j) < end_pos);
    assign wrap_lanes[j] = (SUM_W'(j + NB) < end_pos);
  end
endmodule

// File: rtl/dma_lane_packer.sv
module dma_lane_packer
  import dlp_pkg::*;
#(
  parameter int BUS_W = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_start,
  input  logic [$clog2(BUS_W/8)-1:0]     cfg_src_ofs,
  input  logic [$clog2(BUS_W/8)-1:0]     cfg_dst_ofs,
  input  logic [$clog2($clog2(BUS_W/8)+1)-1:0] cfg_size,
  input  logic                           cfg_dst_fixed,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [BUS_W-1:0]               in_data,
  input  logic                           in_last,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [BUS_W-1:0]               out_data,
  output logic [BUS_W/8-1:0]             out_strb
);
  localparam int NB    = BUS_W / BYTE_W;
  localparam int OFS_W = $clog2(NB);
  localparam int SZ_W  = $clog2(OFS_W + 1);
  localparam int CNT_W = OFS_W + 1;

  function automatic logic [BUS_W-1:0] lanes_to_bits(input logic [NB-1:0] lanes);
    logic [BUS_W-1:0] bits;
    for (int i = 0; i < NB; i++) begin
      bits[i*BYTE_W +: BYTE_W] = {BYTE_W{lanes[i]}};
    end
    return bits;
  endfunction

  // Internal reset, released in step with the clock
  logic rst_i_n;

  dlp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Configuration and pointer state
  dst_mode_e          fixed_q;
  logic [SZ_W-1:0]    size_q;
  logic [OFS_W-1:0]   src_ptr_q, src_ptr_d;
  logic [OFS_W-1:0]   dst_ptr_q, dst_ptr_d;
  logic               active_q, active_d;
  logic               flush_q, flush_d;

  // Residue and output register
  logic [BUS_W-1:0]   acc_data_q, acc_data_d;
  logic [NB-1:0]      acc_strb_q, acc_strb_d;
  logic               ov_q, ov_d;
  logic [BUS_W-1:0]   od_q, od_d;
  logic [NB-1:0]      os_q, os_d;

  // Datapath nets
  logic [CNT_W-1:0]   beat_bytes;
  logic [OFS_W-1:0]   shift;
  logic [BUS_W-1:0]   rot_data;
  logic [NB-1:0]      win_low, win_wrap;
  logic [OFS_W-1:0]   win_next;
  logic               win_cross;
  logic               out_free, fire, cfg_ld;
  logic [BUS_W-1:0]   merged_data;
  logic [NB-1:0]      merged_strb;

  assign beat_bytes = CNT_W'(1) << size_q;
  assign shift      = dst_ptr_q - src_ptr_q;

  dlp_lane_rotator #(.NB(NB)) u_rot (
    .din    (in_data),
    .amount (shift),
    .dout   (rot_data)
  );

  dlp_lane_window #(.NB(NB)) u_win (
    .base       (dst_ptr_q),
    .count      (beat_bytes),
    .low_lanes  (win_low),
    .wrap_lanes (win_wrap),
    .next_base  (win_next),
    .crosses    (win_cross)
  );

  assign out_free = !ov_q || out_ready;
  assign in_ready = active_q && out_free && !flush_q;
  assign fire     = in_valid && in_ready;
  assign cfg_ld   = cfg_start && !active_q && !flush_q;

  assign merged_data = acc_data_q | (rot_data & lanes_to_bits(win_low));
  assign merged_strb = acc_strb_q | win_low;

  // Next-state logic
  always_comb begin
    src_ptr_d  = src_ptr_q;
    dst_ptr_d  = dst_ptr_q;
    active_d   = active_q;
    flush_d    = flush_q;
    acc_data_d = acc_data_q;
    acc_strb_d = acc_strb_q;
    ov_d       = ov_q && !out_ready;
    od_d       = od_q;
    os_d       = os_q;

    if (flush_q && out_free) begin
      ov_d       = 1'b1;
      od_d       = acc_data_q;
      os_d       = acc_strb_q;
      acc_data_d = '0;
      acc_strb_d = '0;
      flush_d    = 1'b0;
    end

    if (cfg_ld) begin
      active_d   = 1'b1;
      src_ptr_d  = cfg_src_ofs;
      dst_ptr_d  = cfg_dst_ofs;
      acc_data_d = '0;
      acc_strb_d = '0;
    end

    if (fire) begin
      src_ptr_d = src_ptr_q + beat_bytes[OFS_W-1:0];
      if (in_last) begin
        active_d = 1'b0;
      end
      if (fixed_q == DST_FIXED) begin
        ov_d = 1'b1;
        od_d = rot_data & lanes_to_bits(win_low | win_wrap);
        os_d = win_low | win_wrap;
      end else begin
        dst_ptr_d = win_next;
        if (win_cross || in_last) begin
          ov_d       = 1'b1;
          od_d       = merged_data;
          os_d       = merged_strb;
          acc_data_d = rot_data & lanes_to_bits(win_wrap);
          acc_strb_d = win_wrap;
          flush_d    = in_last && (|win_wrap);
        end else begin
          acc_data_d = merged_data;
          acc_strb_d = merged_strb;
        end
      end
    end
  end

  // Configuration registers, enabled by a load
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      fixed_q <= DST_INCR;
      size_q  <= '0;
    end else if (cfg_ld) begin
      fixed_q <= cfg_dst_fixed ? DST_FIXED : DST_INCR;
      size_q  <= cfg_size;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      src_ptr_q <= '0;
      dst_ptr_q <= '0;
      active_q  <= 1'b0;
      flush_q   <= 1'b0;
      ov_q      <= 1'b0;
    end else begin
      src_ptr_q <= src_ptr_d;
      dst_ptr_q <= dst_ptr_d;
      active_q  <= active_d;
      flush_q   <= flush_d;
      ov_q      <= ov_d;
    end
  end

  // Data registers, enabled only when they can change
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      acc_data_q <= '0;
      acc_strb_q <= '0;
    end else if (fire || cfg_ld || (flush_q && out_free)) begin
      acc_data_q <= acc_data_d;
      acc_strb_q <= acc_strb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      od_q <= '0;
      os_q <= '0;
    end else if (out_free) begin
      od_q <= od_d;
      os_q <= os_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_strb  = os_q;
endmodule

// File: rtl/dma_lane_packer_chk.sv
module dma_lane_packer_chk #(
  parameter int BUS_W = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 in_last,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [BUS_W-1:0]     out_data,
  input logic [BUS_W/8-1:0]   out_strb,
  input logic                 fixed_mode,
  input logic [$clog2($clog2(BUS_W/8)+1)-1:0] size_code
);
  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_strb));

  p_stall_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_strb_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_strb != '0));

  p_no_input_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready);

  p_fixed_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && fixed_mode |=>
      out_valid && ($countones(out_strb) == (1 << $past(size_code))));
endmodule

bind dma_lane_packer dma_lane_packer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_last    (in_last),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_strb   (out_strb),
  .fixed_mode (fixed_q == dlp_pkg::DST_FIXED),
  .size_code  (size_q)
);

// File: tb/dma_lane_packer_bench.sv
module dma_lane_packer_bench;
  localparam int BUS_W = 64;
  localparam int NB    = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_start = 1'b0;
  logic [2:0]        cfg_src_ofs = '0;
  logic [2:0]        cfg_dst_ofs = '0;
  logic [1:0]        cfg_size = '0;
  logic              cfg_dst_fixed = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [BUS_W-1:0]  in_data = '0;
  logic              in_last = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [BUS_W-1:0]  out_data;
  logic [NB-1:0]     out_strb;

  int tests = 0;
  int fails = 0;
  bit rand_ready = 1'b0;
  bit done = 1'b0;
  logic [7:0] bval = 8'h01;

  logic [BUS_W-1:0] q_data[$];
  logic [NB-1:0]    q_strb[$];
  string            q_tag[$];

  always #2.5 clk = ~clk;

  dma_lane_packer #(.BUS_W(BUS_W)) u_dma_lane_packer (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_src_ofs(cfg_src_ofs),
    .cfg_dst_ofs(cfg_dst_ofs), .cfg_size(cfg_size), .cfg_dst_fixed(cfg_dst_fixed),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_strb(out_strb)
  );

  task automatic check(input bit ok, input string tag, input logic [BUS_W-1:0] act,
                       input logic [BUS_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Ready pattern generator
  int rcnt = 0;
  always @(posedge clk) begin
    #1;
    rcnt++;
    out_ready <= rand_ready ? (((rcnt * 7) % 5) > 1) : 1'b1;
  end

  // Monitor / scoreboard
  logic             prev_stall = 1'b0;
  logic [BUS_W-1:0] prev_d;
  logic [NB-1:0]    prev_s;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)   // R9 hold
        check(out_valid && out_data == prev_d && out_strb == prev_s, "R9 hold",
              {out_data}, prev_d);
      if (out_valid && !out_ready)   // R9 back-pressure
        check(!in_ready, "R9 in_ready", 64'(in_ready), 64'd0);
      prev_stall = out_valid && !out_ready;
      prev_d     = out_data;
      prev_s     = out_strb;
      if (out_valid && out_ready) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R5 unexpected entry", out_data, '0);
        end else begin
          logic [BUS_W-1:0] ed;
          logic [NB-1:0]    es;
          string            et;
          ed = q_data.pop_front();
          es = q_strb.pop_front();
          et = q_tag.pop_front();
          check(out_data == ed, {et, " data"}, out_data, ed);
          check(out_strb == es, {et, " strb R10"}, 64'(out_strb), 64'(es));
        end
      end
    end
  end

  task automatic push_exp(input logic [BUS_W-1:0] d, input logic [NB-1:0] s, input string tag);
    q_data.push_back(d);
    q_strb.push_back(s);
    q_tag.push_back(tag);
  endtask

  // Driver: one transfer, with the expected entries computed byte by byte
  task automatic run_xfer(input int src, input int dst, input int szc, input bit fixed,
                          input int nbeats, input bit poke_cfg, input string tag);
    int sz;
    int sp;
    int dp;
    logic [BUS_W-1:0] acc;
    logic [NB-1:0]    st;
    while (q_data.size() != 0 || out_valid) @(negedge clk);
    @(posedge clk); #1;
    cfg_start = 1'b1; cfg_src_ofs = 3'(src); cfg_dst_ofs = 3'(dst);
    cfg_size = 2'(szc); cfg_dst_fixed = fixed;
    @(posedge clk); #1;
    cfg_start = 1'b0;
    sz = 1 << szc; sp = src; dp = dst; acc = '0; st = '0;
    for (int b = 0; b < nbeats; b++) begin
      logic [BUS_W-1:0] beat;
      logic [BUS_W-1:0] fd;
      logic [NB-1:0]    fs;
      beat = {8{8'hA5}};
      fd = '0; fs = '0;
      for (int k = 0; k < sz; k++) begin
        beat[((sp + k) % NB)*8 +: 8] = bval;
        if (fixed) begin
          fd[((dst + k) % NB)*8 +: 8] = bval;
          fs[(dst + k) % NB] = 1'b1;
        end else begin
          acc[dp*8 +: 8] = bval;
          st[dp] = 1'b1;
          dp = (dp + 1) % NB;
          if (dp == 0) begin
            push_exp(acc, st, tag);
            acc = '0; st = '0;
          end
        end
        bval = bval + 8'd1;
      end
      if (fixed) push_exp(fd, fs, tag);
      if (!fixed && b == nbeats - 1 && st != '0) push_exp(acc, st, tag);
      in_valid = 1'b1; in_data = beat; in_last = (b == nbeats - 1);
      if (poke_cfg && b == 1) begin   // R2: ignored while busy
        cfg_start = 1'b1; cfg_src_ofs = 3'd7; cfg_dst_ofs = 3'd1;
        cfg_size = 2'd0; cfg_dst_fixed = ~fixed;
      end
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      cfg_start = 1'b0;
      sp = (sp + sz) % NB;
    end
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    check(!in_ready, {tag, " R7 idle after last"}, 64'(in_ready), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 out_valid", 64'(out_valid), 64'd0);
    check(!in_ready,  "R1 in_ready",  64'(in_ready),  64'd0);

    run_xfer(3, 5, 2, 1'b0, 6, 1'b0, "R3/R6 rotate");
    run_xfer(0, 0, 2, 1'b0, 4, 1'b0, "R5 pack");
    run_xfer(1, 6, 3, 1'b0, 3, 1'b0, "R7 wrap last");
    run_xfer(2, 3, 0, 1'b0, 5, 1'b0, "R7 partial");
    run_xfer(5, 2, 1, 1'b0, 7, 1'b0, "R4 size");
    run_xfer(4, 6, 2, 1'b1, 3, 1'b0, "R8 fixed wrap");
    run_xfer(0, 3, 1, 1'b1, 4, 1'b0, "R8 fixed");
    run_xfer(6, 1, 2, 1'b0, 5, 1'b1, "R2 busy start");
    rand_ready = 1'b1;
    run_xfer(3, 5, 2, 1'b0, 9, 1'b0, "R9 stall rotate");
    run_xfer(7, 4, 3, 1'b0, 4, 1'b0, "R9 stall wrap");
    run_xfer(2, 7, 2, 1'b1, 4, 1'b1, "R8 stall fixed");
    while (q_data.size() != 0 || out_valid) @(negedge clk);
    rand_ready = 1'b0;
    check(q_data.size() == 0, "R5 all entries seen", 64'(q_data.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule